// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast oscillator clock down to a comparison rate. Internally it works like a dual-modulus prescaler that divides by M or M+1, steered by a swallow count A and a main count N. One output period therefore lasts M·N + A fast cycles. The swallow count sets how many prescaler cycles at the start of each period use the longer modulus M+1. The remaining N−A prescaler cycles use M.

Settings are applied with a single load strobe and checked when they arrive. A legal setting is held until the current output period ends, and it becomes active exactly at that boundary. An illegal setting is rejected with a one-cycle error flag, and the active values stay as they were. Everything runs in the fast clock domain, with a synchronous reset.

Top module: `swallowDivider`

## Requirements
- R1: Between consecutive output pulses there are exactly M·N + A fast clock cycles, where M, N and A are the active settings.
- R2: With `modSel` high the base modulus M is 64; with `modSel` low it is 128.
- R3: With A equal to 0 the period is exactly M·N cycles, so no prescaler cycle is lengthened.
- R4: The extreme legal settings N = 5 and A = N−1 (including a swallow count of 127) give the ratio of R1.
- R5: `fpOut` is high for exactly one fast clock cycle per period.
- R6: A legal setting loaded during a period does not change that period; it governs the periods that follow the next pulse.
- R7: A load with N < 5 or A ≥ N raises `cfgErr` for exactly the cycle after the strobe, and the active settings keep their earlier values, so the output spacing is unchanged.
- R8: A legal load never raises `cfgErr`.
- R9: During reset `fpOut` and `cfgErr` are low. After reset the active setting is M = 64, A = 0, N = 5, so the first pulse goes high on the 320th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| modSel | input | 1 | Modulus select: 1 gives 64/65, 0 gives 128/129 |
| swallowIn | input | 7 | Swallow count A, 0 to 127 |
| mainIn | input | 11 | Main count N, 5 to 2047 |
| loadStb | input | 1 | One-cycle strobe that captures modSel, swallowIn and mainIn |
| fpOut | output | 1 | Divided comparison pulse, one cycle wide |
| cfgErr | output | 1 | One-cycle flag after a load with illegal values |

## Verification
A wrong prescaler count, or a wrong swallow or main index, changes the spacing of `fpOut`. The error appears in the first period that uses the faulty state, at most M·N + A cycles after it arises. It is caught by comparing every measured interval with the value the active setting predicts. A setting applied too early or too late shows up as a wrong length in the period that straddles the load. A rejected setting that leaks into the active registers alters the next interval. Error flag timing is seen one cycle after each strobe.

// File: rtl/swallowPkg.sv
package swallowPkg;
  parameter int SWAL_W    = 7;
  parameter int MAIN_W    = 11;
  parameter int MOD_SMALL = 64;
  parameter int MOD_LARGE = 128;
  parameter int MIN_MAIN  = 5;
  localparam int PRE_W    = $clog2(MOD_LARGE + 1);
  localparam int MIN_PERIOD = MOD_SMALL * MIN_MAIN;

  // one divide setting: modulus choice, swallow count, main count
  typedef struct packed {
    logic              selSmall;
    logic [SWAL_W-1:0] swal;
    logic [MAIN_W-1:0] main;
  } divCfg_t;

  // strobes from control to the prescaler datapath
  typedef struct packed {
    logic useLarge;
    logic addOne;
  } preStrb_t;
endpackage

// File: rtl/prescalerPath.sv
module prescalerPath
  import swallowPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  preStrb_t strb,
  output logic     preWrap
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] baseLast;
  logic [PRE_W-1:0] lastCnt;

  assign baseLast = strb.useLarge ? PRE_W'(MOD_LARGE - 1) : PRE_W'(MOD_SMALL - 1);
  assign lastCnt  = baseLast + PRE_W'(strb.addOne);
  assign preWrap  = (preCnt == lastCnt);

  always_ff @(posedge clk) begin
    if (rst)          preCnt <= '0;
    else if (preWrap) preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end
endmodule

// File: rtl/swallowCtrl.sv
module swallowCtrl
  import swallowPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     loadStb,
  input  divCfg_t  newCfg,
  input  logic     preWrap,
  output preStrb_t strb,
  output logic     periodEnd,
  output logic     cfgErr,
  output divCfg_t  actCfg
);
  localparam divCfg_t RST_CFG = '{selSmall: 1'b1, swal: '0, main: MAIN_W'(MIN_MAIN)};

  divCfg_t           pendCfg;
  logic              pendValid;
  logic [MAIN_W-1:0] cycIdx;
  logic [MAIN_W-1:0] lastIdx;
  logic              newLegal;

  assign newLegal = (newCfg.main >= MAIN_W'(MIN_MAIN)) &&
                    (MAIN_W'(newCfg.swal) < newCfg.main);
  assign lastIdx  = actCfg.main - MAIN_W'(1);

  // early prescaler cycles of each period take the longer modulus
  assign strb.addOne   = (cycIdx < MAIN_W'(actCfg.swal));
  assign strb.useLarge = ~actCfg.selSmall;
  assign periodEnd     = preWrap && (cycIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycIdx <= '0;
    end else if (periodEnd) begin
      cycIdx <= '0;
    end else if (preWrap) begin
      cycIdx <= cycIdx + MAIN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actCfg    <= RST_CFG;
      pendCfg   <= RST_CFG;
      pendValid <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      cfgErr <= loadStb && !newLegal;
      if (periodEnd && pendValid) begin
        actCfg    <= pendCfg;
        pendValid <= 1'b0;
      end
      if (loadStb && newLegal) begin
        pendCfg   <= newCfg;
        pendValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swallowDivider.sv
module swallowDivider
  import swallowPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modSel,
  input  logic [SWAL_W-1:0] swallowIn,
  input  logic [MAIN_W-1:0] mainIn,
  input  logic              loadStb,
  output logic              fpOut,
  output logic              cfgErr
);
  divCfg_t  newCfg;
  divCfg_t  actCfg;
  preStrb_t strb;
  logic     preWrap;
  logic     periodEnd;

  assign newCfg = '{selSmall: modSel, swal: swallowIn, main: mainIn};

  swallowCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .loadStb   (loadStb),
    .newCfg    (newCfg),
    .preWrap   (preWrap),
    .strb      (strb),
    .periodEnd (periodEnd),
    .cfgErr    (cfgErr),
    .actCfg    (actCfg)
  );

  prescalerPath u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .preWrap (preWrap)
  );

  always_ff @(posedge clk) begin
    if (rst) fpOut <= 1'b0;
    else     fpOut <= periodEnd;
  end
endmodule

// File: rtl/swallowDivider_chk.sv
module swallowDivider_chk
  import swallowPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              modSel,
  input logic [SWAL_W-1:0] swallowIn,
  input logic [MAIN_W-1:0] mainIn,
  input logic              loadStb,
  input logic              fpOut,
  input logic              cfgErr,
  input logic              periodEnd,
  input divCfg_t           actCfg
);
  localparam int GAP_W = 20;
  logic             inLegal;
  logic [GAP_W-1:0] sinceFp;

  assign inLegal = (mainIn >= MAIN_W'(MIN_MAIN)) && (MAIN_W'(swallowIn) < mainIn);

  always_ff @(posedge clk) begin
    if (rst || fpOut)    sinceFp <= '0;
    else if (~&sinceFp)  sinceFp <= sinceFp + GAP_W'(1);
  end

  a_r5_fp_one_wide: assert property (@(posedge clk) disable iff (rst)
    fpOut |=> !fpOut);

  a_r7_err_after_illegal: assert property (@(posedge clk) disable iff (rst)
    (loadStb && !inLegal) |=> cfgErr);

  a_r8_quiet_after_legal: assert property (@(posedge clk) disable iff (rst)
    (loadStb && inLegal) |=> !cfgErr);

  a_r7_err_needs_load: assert property (@(posedge clk) disable iff (rst)
    !loadStb |=> !cfgErr);

  a_r6_cfg_held_mid_period: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(actCfg));

  a_r5_pulse_after_end: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> fpOut);

  a_r7_active_legal: assert property (@(posedge clk) disable iff (rst)
    (actCfg.main >= MAIN_W'(MIN_MAIN)) && (MAIN_W'(actCfg.swal) < actCfg.main));

  a_r1_min_spacing: assert property (@(posedge clk) disable iff (rst)
    fpOut |-> (sinceFp >= GAP_W'(MIN_PERIOD - 1)));
endmodule

bind swallowDivider swallowDivider_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .modSel    (modSel),
  .swallowIn (swallowIn),
  .mainIn    (mainIn),
  .loadStb   (loadStb),
  .fpOut     (fpOut),
  .cfgErr    (cfgErr),
  .periodEnd (periodEnd),
  .actCfg    (actCfg)
);

// File: tb/swallowDivider_bench.sv
module swallowDivider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modSel = 1'b1;
  logic [6:0]  swallowIn = '0;
  logic [10:0] mainIn = 11'd5;
  logic        loadStb = 1'b0;
  logic        fpOut;
  logic        cfgErr;

  int    checks = 0;
  int    errors = 0;
  int    expQ[$];
  string tagQ[$];
  int    curRatio;
  int    gapCnt = 0;
  logic  prevFp = 1'b0;

  always #2.5 clk = ~clk;

  swallowDivider u_swallowDivider (
    .clk(clk), .rst(rst), .modSel(modSel), .swallowIn(swallowIn),
    .mainIn(mainIn), .loadStb(loadStb), .fpOut(fpOut), .cfgErr(cfgErr)
  );

  function automatic int ratioOf(input logic sel, input int a, input int n);
    return (sel ? 64 : 128) * n + a;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitFp();
    do @(negedge clk); while (!fpOut);
  endtask

  // driver: loads at a period start, queues expected lengths of the periods that follow
  task automatic runCfg(input logic sel, input int a, input int n, input int periods, input string tag);
    logic legal;
    legal = (n >= 5) && (a < n);
    waitFp();
    modSel = sel; swallowIn = 7'(a); mainIn = 11'(n); loadStb = 1'b1;
    expQ.push_back(curRatio); tagQ.push_back("R6");
    @(negedge clk);
    loadStb = 1'b0;
    check(legal ? "R8" : "R7", int'(cfgErr), legal ? 0 : 1);
    @(negedge clk);
    check("R7", int'(cfgErr), 0);
    if (legal) curRatio = ratioOf(sel, a, n);
    for (int i = 0; i < periods; i++) begin
      waitFp();
      expQ.push_back(curRatio); tagQ.push_back(tag);
    end
  endtask

  // monitor: measures every interval between pulses and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        gapCnt = 0;
        prevFp = 1'b0;
      end else begin
        gapCnt++;
        if (fpOut && prevFp) check("R5", 1, 0);
        if (fpOut) begin
          if (expQ.size() == 0) check("R1", gapCnt, -1);
          else begin
            string t;
            int    e;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(t, gapCnt, e);
          end
          gapCnt = 0;
        end
        prevFp = fpOut;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9", int'(fpOut), 0);
    check("R9", int'(cfgErr), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    // first pulse on the 320th rising edge; counted from the negedge before the first active edge
    curRatio = 320;
    expQ.push_back(321); tagQ.push_back("R9");

    runCfg(1'b1, 0, 7, 2, "R3");
    runCfg(1'b0, 0, 7, 2, "R2");
    runCfg(1'b0, 6, 7, 2, "R4");
    runCfg(1'b1, 4, 5, 2, "R4");
    runCfg(1'b1, 127, 130, 1, "R4");
    runCfg(1'b1, 0, 4, 1, "R7");
    runCfg(1'b0, 9, 9, 1, "R7");
    runCfg(1'b1, 20, 3, 1, "R7");
    for (int k = 0; k < 12; k++) begin
      int n;
      int a;
      n = int'($urandom_range(20, 5));
      a = int'($urandom_range(n - 1, 0));
      runCfg(1'($urandom_range(1, 0)), a, n, 2, "R1");
    end
    waitFp();
    @(negedge clk);
    check("R1", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule